// File: doc/BRIEF.md
# Floating-Point Exception Mask and Deferred Fault Unit

This block sits beside a floating-point execution pipeline and keeps the numeric control word and the exception and condition part of the numeric status word. The execution unit reports raw exception events as a six-bit vector. Each reported condition sets a sticky flag. For each condition that is masked, the block tells the datapath to apply the built-in default result. A masked zero-divide, for example, yields infinity and nothing stops.

A condition whose mask bit is clear does not fault when it occurs. It is recorded as pending. The fault is delivered only when the next floating-point instruction is issued, or when an explicit wait command checks the pending state. While pending is set and no handler acknowledge has arrived, that check holds a busy (stall) output high. The fault request it raises stays high until the handler acknowledges it.

The block also holds the four condition-code bits. It maps three of them to the integer carry, parity and zero flags.

Exception bit order, used both for the event vector and for the low six bits of the control word and the status word: 0 invalid operation, 1 denormal operand, 2 zero-divide, 3 overflow, 4 underflow, 5 precision.

Top module: `fexc_unit`

## Requirements
- R1: After reset the control word reads 0x037F, so all six masks are set. The status word reads 0x0000, and `fault_o` and `busy_o` are low.
- R2: An event with `ev_valid` high sets the matching flag bits in status bits 5:0 at the next clock edge. The flags are sticky: later events OR into them, and nothing except clear, initialize or a status load removes a flag.
- R3: `clr_exc` clears status bits 5:0 and the summary bit, and leaves the control word and the condition codes as they were. `init` sets the control word to 0x037F and clears the whole status word.
- R4: While `ev_valid` is high, `dflt_o` equals `ev_flags` AND the mask bits in the same cycle. Bit 2 set means the default infinity result for a zero-divide. An event that is fully masked creates no pending state, and a check made afterwards does not stall.
- R5: Status bit 7 (summary) is the OR over the six conditions of flag AND NOT mask. A control-word write that clears mask bit 2 makes an already-set zero-divide flag pending from the next cycle.
- R6: A pending condition does not raise `fault_o` by itself. `fault_o` rises one cycle after a check (`fp_issue` or `wait_cmd`) sees pending with no `hnd_ack`. It then stays high until `hnd_ack` is sampled.
- R7: `busy_o` is high in any cycle where a check is requested, pending is set and `hnd_ack` is low. It is low when `hnd_ack` is high or when nothing is pending.
- R8: `cc_valid` loads `cc_in` (bit 3 = C3, bit 2 = C2, bit 1 = C1, bit 0 = C0). These show in status bits 14, 10, 9 and 8 for C3, C2, C1 and C0. `cf_o` equals C0, `pf_o` equals C2 and `zf_o` equals C3.
- R9: `sw_wr` loads the flags from `sw_wdata[5:0]` and the condition codes from bits 14, 10, 9 and 8. A one written to bit 7 is ignored, because the summary bit is always computed.
- R10: `cw_wr` stores all 16 bits of `cw_wdata`, which read back on `cw_rdata` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Exception event strobe from the execution unit |
| ev_flags | input | 6 | Raised exception conditions |
| cc_valid | input | 1 | Condition-code update strobe |
| cc_in | input | 4 | New condition codes, C3 down to C0 |
| cw_wr | input | 1 | Control word load |
| cw_wdata | input | 16 | Control word load value |
| sw_wr | input | 1 | Status word load |
| sw_wdata | input | 16 | Status word load value |
| clr_exc | input | 1 | Clear exception flags |
| init | input | 1 | Initialize control and status words |
| fp_issue | input | 1 | Next floating-point instruction asks to proceed |
| wait_cmd | input | 1 | Explicit wait command |
| hnd_ack | input | 1 | Exception handler acknowledge |
| cw_rdata | output | 16 | Control word |
| sw_rdata | output | 16 | Status word |
| dflt_o | output | 6 | Masked conditions that take the default response |
| fault_o | output | 1 | Deferred fault request to the handler |
| busy_o | output | 1 | Stall while a check finds an unacknowledged pending fault |
| cf_o | output | 1 | Carry flag from C0 |
| pf_o | output | 1 | Parity flag from C2 |
| zf_o | output | 1 | Zero flag from C3 |

## Verification
The bench targets deferral first. An unmasked zero-divide is left idle for several cycles before any check. A design that signals faults eagerly would raise `fault_o` right away. A design that samples the wrong cycle would miss the one-cycle delay after the check.

The bench also unmasks a flag that was set while masked. A design that computes pending only at event time would never report it.

It confirms that `hnd_ack` drops both busy and the fault, and that a fully masked event never stalls a wait.

It moves distinct patterns through the condition-code bits and the status-word load, including a write to the summary bit. A swapped C-bit position or a stored summary bit would then show up at the flags and the readback.

// File: rtl/fexc_pkg.sv
package fexc_pkg;
  parameter int unsigned NUM_EXC = 6;
  parameter int unsigned WORD_W  = 16;
  parameter logic [WORD_W-1:0] CW_INIT = 16'h037F;

  typedef enum int unsigned {
    EX_INV  = 0,
    EX_DEN  = 1,
    EX_ZDIV = 2,
    EX_OVF  = 3,
    EX_UNF  = 4,
    EX_PREC = 5
  } exc_idx_e;

  localparam int unsigned SW_SUM = 7;
  localparam int unsigned SW_C0  = 8;
  localparam int unsigned SW_C1  = 9;
  localparam int unsigned SW_C2  = 10;
  localparam int unsigned SW_C3  = 14;

  typedef struct packed {
    logic c3;
    logic c2;
    logic c1;
    logic c0;
  } ccode_t;
endpackage

// File: rtl/fexc_ctrl_word.sv
module fexc_ctrl_word
  import fexc_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter logic [W-1:0] RST_VAL = CW_INIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cw_o
);
  logic [W-1:0] cw_q, cw_d;
  logic         cw_en;

  always_comb begin
    cw_en = init_i | wr_i;
    cw_d  = init_i ? RST_VAL : wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cw_q <= RST_VAL;
    else if (cw_en) cw_q <= cw_d;
  end

  assign cw_o = cw_q;

  // R3: initialize restores the default control word
  a_r3_init_default: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (cw_q == RST_VAL));

  // R10: without a load the control word holds
  a_r10_cw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !init_i && !wr_i |=> $stable(cw_q));
endmodule

// File: rtl/fexc_status.sv
module fexc_status
  import fexc_pkg::*;
#(
  parameter int unsigned N = NUM_EXC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [N-1:0] wr_flags_i,
  input  ccode_t       wr_cc_i,
  input  logic         ev_valid_i,
  input  logic [N-1:0] ev_flags_i,
  input  logic         cc_valid_i,
  input  ccode_t       cc_i,
  output logic [N-1:0] flags_o,
  output ccode_t       cc_o
);
  logic [N-1:0] flags_q, flags_d;
  ccode_t       cc_q, cc_d;
  logic         flags_en, cc_en;

  // flag next state: init > clear > load > accumulate
  always_comb begin
    flags_d  = flags_q;
    flags_en = 1'b0;
    if (init_i || clr_i) begin
      flags_d  = '0;
      flags_en = 1'b1;
    end else if (wr_i) begin
      flags_d  = wr_flags_i;
      flags_en = 1'b1;
    end else if (ev_valid_i) begin
      flags_d  = flags_q | ev_flags_i;
      flags_en = 1'b1;
    end
  end

  // condition code next state: init > load > update
  always_comb begin
    cc_d  = cc_q;
    cc_en = 1'b0;
    if (init_i) begin
      cc_d  = '0;
      cc_en = 1'b1;
    end else if (wr_i) begin
      cc_d  = wr_cc_i;
      cc_en = 1'b1;
    end else if (cc_valid_i) begin
      cc_d  = cc_i;
      cc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cc_q <= '0;
    else if (cc_en) cc_q <= cc_d;
  end

  assign flags_o = flags_q;
  assign cc_o    = cc_q;

  // R2: flags never drop without clear, init or load
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !init_i && !clr_i && !wr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R3: clear leaves condition codes untouched when no other update
  a_r3_clear_keeps_cc: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !init_i && !wr_i && !cc_valid_i |=> $stable(cc_q));
endmodule

// File: rtl/fexc_fault.sv
module fexc_fault
  import fexc_pkg::*;
#(
  parameter int unsigned N = NUM_EXC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] mask_i,
  input  logic         check_i,
  input  logic         ack_i,
  output logic         pending_o,
  output logic         busy_o,
  output logic         fault_o
);
  logic [N-1:0] unmasked;
  logic         fault_q, fault_d;

  for (genvar g = 0; g < N; g++) begin : g_unm
    assign unmasked[g] = flags_i[g] & ~mask_i[g];
  end

  assign pending_o = |unmasked;

  always_comb begin
    busy_o  = check_i & pending_o & ~ack_i;
    fault_d = fault_q;
    if (ack_i)       fault_d = 1'b0;
    else if (busy_o) fault_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign fault_o = fault_q;

  // R6: fault appears only after a check that found pending
  a_r6_fault_after_check: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_q && !(check_i && pending_o) |=> !fault_q);

  // R6: fault holds until acknowledged
  a_r6_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q && !ack_i |=> fault_q);

  // R7: acknowledge removes the fault request
  a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !fault_q);
endmodule

// File: rtl/fexc_unit.sv
module fexc_unit
  import fexc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  input  logic [5:0]  ev_flags,
  input  logic        cc_valid,
  input  logic [3:0]  cc_in,
  input  logic        cw_wr,
  input  logic [15:0] cw_wdata,
  input  logic        sw_wr,
  input  logic [15:0] sw_wdata,
  input  logic        clr_exc,
  input  logic        init,
  input  logic        fp_issue,
  input  logic        wait_cmd,
  input  logic        hnd_ack,
  output logic [15:0] cw_rdata,
  output logic [15:0] sw_rdata,
  output logic [5:0]  dflt_o,
  output logic        fault_o,
  output logic        busy_o,
  output logic        cf_o,
  output logic        pf_o,
  output logic        zf_o
);
  localparam int unsigned N = NUM_EXC;

  logic [WORD_W-1:0] cw;
  logic [N-1:0]      mask;
  logic [N-1:0]      flags;
  ccode_t            cc, cc_new, cc_load;
  logic              pending;
  logic              check;
  logic              unused_sw;

  assign unused_sw = ^{sw_wdata[15], sw_wdata[13:11], sw_wdata[7:6]};

  assign cc_new  = ccode_t'(cc_in);
  assign cc_load = '{c3: sw_wdata[SW_C3], c2: sw_wdata[SW_C2],
                     c1: sw_wdata[SW_C1], c0: sw_wdata[SW_C0]};
  assign check   = fp_issue | wait_cmd;
  assign mask    = cw[N-1:0];

  fexc_ctrl_word #(.W(WORD_W), .RST_VAL(CW_INIT)) i_cw (
    .clk     (clk),
    .rst_n   (rst_n),
    .init_i  (init),
    .wr_i    (cw_wr),
    .wdata_i (cw_wdata),
    .cw_o    (cw)
  );

  fexc_status #(.N(N)) i_sw (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init),
    .clr_i      (clr_exc),
    .wr_i       (sw_wr),
    .wr_flags_i (sw_wdata[N-1:0]),
    .wr_cc_i    (cc_load),
    .ev_valid_i (ev_valid),
    .ev_flags_i (ev_flags),
    .cc_valid_i (cc_valid),
    .cc_i       (cc_new),
    .flags_o    (flags),
    .cc_o       (cc)
  );

  fexc_fault #(.N(N)) i_flt (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags_i   (flags),
    .mask_i    (mask),
    .check_i   (check),
    .ack_i     (hnd_ack),
    .pending_o (pending),
    .busy_o    (busy_o),
    .fault_o   (fault_o)
  );

  always_comb begin
    dflt_o = ev_valid ? (ev_flags & mask) : '0;

    sw_rdata             = '0;
    sw_rdata[N-1:0]      = flags;
    sw_rdata[SW_SUM]     = pending;
    sw_rdata[SW_C0]      = cc.c0;
    sw_rdata[SW_C1]      = cc.c1;
    sw_rdata[SW_C2]      = cc.c2;
    sw_rdata[SW_C3]      = cc.c3;
  end

  assign cw_rdata = cw;
  assign cf_o     = cc.c0;
  assign pf_o     = cc.c2;
  assign zf_o     = cc.c3;

  // R4: a fully masked event on a clean state creates no pending fault
  a_r4_masked_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ((ev_flags & ~mask) == '0) && !pending && !cw_wr && !sw_wr
    |=> !pending);

  // R7: no stall without a check
  a_r7_busy_needs_check: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_issue && !wait_cmd |-> !busy_o);
endmodule

// File: tb/test_fexc_unit.sv
module test_fexc_unit;
  logic        clk, rst_n;
  logic        ev_valid, cc_valid, cw_wr, sw_wr, clr_exc, init;
  logic        fp_issue, wait_cmd, hnd_ack;
  logic [5:0]  ev_flags;
  logic [3:0]  cc_in;
  logic [15:0] cw_wdata, sw_wdata;
  logic [15:0] cw_rdata, sw_rdata;
  logic [5:0]  dflt_o;
  logic        fault_o, busy_o, cf_o, pf_o, zf_o;

  int n_chk = 0;
  int n_err = 0;

  fexc_unit i_fexc_unit (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_flags(ev_flags),
    .cc_valid(cc_valid), .cc_in(cc_in), .cw_wr(cw_wr), .cw_wdata(cw_wdata),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .clr_exc(clr_exc), .init(init),
    .fp_issue(fp_issue), .wait_cmd(wait_cmd), .hnd_ack(hnd_ack),
    .cw_rdata(cw_rdata), .sw_rdata(sw_rdata), .dflt_o(dflt_o),
    .fault_o(fault_o), .busy_o(busy_o), .cf_o(cf_o), .pf_o(pf_o), .zf_o(zf_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock, sampled at the following falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ev_valid = 0; ev_flags = '0; cc_valid = 0; cc_in = '0;
    cw_wr = 0; cw_wdata = '0; sw_wr = 0; sw_wdata = '0;
    clr_exc = 0; init = 0; fp_issue = 0; wait_cmd = 0; hnd_ack = 0;
  endtask

  task automatic post_event(input logic [5:0] f);
    ev_valid = 1; ev_flags = f;
    #1;
  endtask

  task automatic t_reset();
    check("R1 cw", cw_rdata, 16'h037F);
    check("R1 sw", sw_rdata, 16'h0000);
    check("R1 fault", {15'd0, fault_o}, 16'd0);
    check("R1 busy", {15'd0, busy_o}, 16'd0);
  endtask

  task automatic t_masked();
    post_event(6'b000100);
    check("R4 dflt zero-divide", {10'd0, dflt_o}, 16'h0004);
    tick(); idle_inputs();
    check("R2 flag set", {10'd0, sw_rdata[5:0]}, 16'h0004);
    check("R5 no summary when masked", {15'd0, sw_rdata[7]}, 16'd0);
    wait_cmd = 1; #1;
    check("R4 masked wait no stall", {15'd0, busy_o}, 16'd0);
    tick(); idle_inputs();
    check("R4 masked no fault", {15'd0, fault_o}, 16'd0);
    post_event(6'b001000);
    tick(); idle_inputs();
    check("R2 sticky accumulate", {10'd0, sw_rdata[5:0]}, 16'h000C);
  endtask

  task automatic t_clear();
    cc_valid = 1; cc_in = 4'b0001;
    tick(); idle_inputs();
    clr_exc = 1;
    tick(); idle_inputs();
    check("R3 clear flags", sw_rdata, 16'h0100);
    check("R3 clear keeps cw", cw_rdata, 16'h037F);
  endtask

  task automatic t_deferred();
    cw_wr = 1; cw_wdata = 16'h037B;
    tick(); idle_inputs();
    check("R10 cw readback", cw_rdata, 16'h037B);
    post_event(6'b000100);
    check("R4 unmasked no default", {10'd0, dflt_o}, 16'h0000);
    tick(); idle_inputs();
    check("R5 summary set", {15'd0, sw_rdata[7]}, 16'd1);
    tick(); tick(); tick();
    check("R6 no fault before check", {15'd0, fault_o}, 16'd0);
    check("R7 no busy before check", {15'd0, busy_o}, 16'd0);
    fp_issue = 1; #1;
    check("R7 busy on issue", {15'd0, busy_o}, 16'd1);
    tick();
    check("R6 fault after check", {15'd0, fault_o}, 16'd1);
    tick();
    check("R6 fault held", {15'd0, fault_o}, 16'd1);
    hnd_ack = 1; #1;
    check("R7 ack releases busy", {15'd0, busy_o}, 16'd0);
    tick(); idle_inputs();
    check("R6 ack clears fault", {15'd0, fault_o}, 16'd0);
    clr_exc = 1;
    tick(); idle_inputs();
    check("R5 summary cleared", {15'd0, sw_rdata[7]}, 16'd0);
  endtask

  task automatic t_late_unmask();
    cw_wr = 1; cw_wdata = 16'h037F;
    tick(); idle_inputs();
    post_event(6'b000100);
    tick(); idle_inputs();
    check("R5 masked flag no summary", {15'd0, sw_rdata[7]}, 16'd0);
    cw_wr = 1; cw_wdata = 16'h037B;
    tick(); idle_inputs();
    check("R5 unmask makes pending", {15'd0, sw_rdata[7]}, 16'd1);
    wait_cmd = 1; #1;
    check("R7 wait stalls", {15'd0, busy_o}, 16'd1);
    tick(); idle_inputs();
    hnd_ack = 1; clr_exc = 1;
    tick(); idle_inputs();
    check("R6 fault acked", {15'd0, fault_o}, 16'd0);
  endtask

  task automatic t_cc();
    cc_valid = 1; cc_in = 4'b1101;
    tick(); idle_inputs();
    check("R8 sw cc pattern a", sw_rdata & 16'h4700, 16'h4500);
    check("R8 flags a", {13'd0, cf_o, pf_o, zf_o}, 16'h0007);
    cc_valid = 1; cc_in = 4'b0010;
    tick(); idle_inputs();
    check("R8 sw cc pattern b", sw_rdata & 16'h4700, 16'h0200);
    check("R8 flags b", {13'd0, cf_o, pf_o, zf_o}, 16'h0000);
    cc_valid = 1; cc_in = 4'b0100;
    tick(); idle_inputs();
    check("R8 flags c", {13'd0, cf_o, pf_o, zf_o}, 16'h0002);
  endtask

  task automatic t_swload();
    cw_wr = 1; cw_wdata = 16'h037F;
    tick(); idle_inputs();
    sw_wr = 1; sw_wdata = 16'h4121;
    tick(); idle_inputs();
    check("R9 sw load", sw_rdata, 16'h4121);
    sw_wr = 1; sw_wdata = 16'h0080;
    tick(); idle_inputs();
    check("R9 summary write ignored", sw_rdata, 16'h0000);
  endtask

  task automatic t_init();
    cw_wr = 1; cw_wdata = 16'h0C00;
    tick(); idle_inputs();
    check("R10 cw full width", cw_rdata, 16'h0C00);
    post_event(6'b100001); cc_valid = 1; cc_in = 4'b1111;
    tick(); idle_inputs();
    check("R5 all unmasked summary", {15'd0, sw_rdata[7]}, 16'd1);
    init = 1;
    tick(); idle_inputs();
    check("R3 init cw", cw_rdata, 16'h037F);
    check("R3 init sw", sw_rdata, 16'h0000);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    tick(); tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_masked();
    t_clear();
    t_deferred();
    t_late_unmask();
    t_cc();
    t_swload();
    t_init();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule